// File: doc/BRIEF.md
# SPI Slave Pause Synchroniser

This block sits in front of the command engine of an SPI slave and handles the pause function. A pause input, active low, lets the bus master stop a transfer part-way without deselecting the slave. The chip-select, serial clock, pause and data inputs are sampled by a fast system clock. Each one passes through a multi-stage synchroniser before any edge is detected.

The block produces a pause flag and two clock-edge strobes for the command engine's shift and bit-count logic. The strobes are already qualified: they are suppressed while a pause is in force, so the engine's count cannot move during a pause. The block also masks the engine's output-enable request, which turns the serial output to high impedance while paused or deselected. A pause only starts or ends while the serial clock is low. If the pause line changes while the clock is high, the change waits for the next clock fall. Deselecting the slave clears the pause and raises a one-cycle abort strobe, so the engine can drop the partial transfer.

Top module: `spi_hold_sync`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it, `hold_active`, `shift_rise`, `shift_fall`, `xfer_abort` and `so_oe` are all 0, and `sel_active` is 0.
- R2: Every pin passes through a synchroniser of SYNC_STAGES flops (default 2). With the defaults, a change of `hold_n_pin` made while the serial clock is low and the slave is selected shows on `hold_active` after the third rising system-clock edge following the change, and not after the second.
- R3: With the slave selected and synchronised SCK low, a low pause line sets `hold_active` without waiting for any SCK edge.
- R4: If the pause line goes low while synchronised SCK is high, `hold_active` stays 0 until SCK falls, then rises with the R2 latency counted from that fall.
- R5: With synchronised SCK low, a high pause line clears `hold_active` at once (R2 latency).
- R6: If the pause line goes high while SCK is high, `hold_active` stays 1 until SCK falls, then clears with the R2 latency counted from that fall.
- R7: With the slave selected and not paused, each SCK rise gives exactly one one-cycle `shift_rise` pulse, and each SCK fall gives exactly one `shift_fall` pulse.
- R8: No `shift_rise` or `shift_fall` pulse is issued while `hold_active` is 1. No pulse is issued on the SCK fall at which a pause begins or ends.
- R9: `so_oe` equals `so_oe_req` while selected and not paused. It is 0 while `hold_active` is 1 or the slave is deselected.
- R10: A rise of the chip-select line (active low) clears `hold_active` and issues one one-cycle `xfer_abort` pulse. `hold_active` stays 0 for as long as chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| si_pin | input | 1 | Serial data input pin |
| so_oe_req | input | 1 | Output-enable request from the command engine |
| hold_active | output | 1 | Pause in force; freezes the command engine |
| sel_active | output | 1 | Synchronised select state, 1 when selected |
| shift_rise | output | 1 | Qualified SCK rising-edge strobe |
| shift_fall | output | 1 | Qualified SCK falling-edge strobe |
| si_sync | output | 1 | Synchronised serial data |
| so_oe | output | 1 | Serial output enable after pause masking |
| xfer_abort | output | 1 | One-cycle strobe on deselect |

## Verification
The pause line is driven low and high once with SCK resting low and once with SCK resting high. The low case shows immediate entry and release, and its exact latency. The high case shows that the change is held back until the next clock fall. Serial clock pulses are sent both while running and while paused. Counting the strobes separates edges that reach the engine from edges that must be swallowed, including the fall on which a pause starts or ends. A deselect made during a pause shows that the pause is cleared and that a single abort strobe is issued.

// File: rtl/spi_hold_pkg.sv
// Package: shared pin indices and reset levels for the pause synchroniser.
// Assumes pins are bundled into one vector in the order given by the indices.
package spi_hold_pkg;
    localparam int PIN_CS   = 0;
    localparam int PIN_SCK  = 1;
    localparam int PIN_HOLD = 2;
    localparam int PIN_SI   = 3;
    localparam int NUM_PINS = 4;
    // Idle level of each pin: deselected, clock low, no pause, data low.
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b0101;
endpackage

// File: rtl/shp_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherence is guaranteed.
module shp_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                // Later stages let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/shp_edge.sv
// Module: rise and fall detector for a vector of synchronised signals.
// Assumes inputs are already in the clk domain; strobes last one cycle.
module shp_edge #(
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev;

    // Remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= sig;
    end

    assign rise = sig & ~prev;
    assign fall = ~sig & prev;
endmodule

// File: rtl/shp_hold_ctl.sv
// Module: pause state and strobe qualification.
// Assumes synchronised, active-low chip select and pause inputs. The pause
// state only moves while SCK is low, so a change made with SCK high takes
// effect on the next SCK fall.
module shp_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    input  logic sck_rise,
    input  logic sck_fall,
    input  logic cs_rise,
    input  logic so_oe_req,
    output logic hold_active,
    output logic shift_rise,
    output logic shift_fall,
    output logic so_oe,
    output logic xfer_abort
);
    logic hold_q;

    // Pause state: cleared by deselect, follows the pause line while SCK is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 1'b0;
        else if (cs_n_s) hold_q <= 1'b0;
        else if (!sck_s) hold_q <= ~hold_n_s;
    end

    // Strobes reach the engine only while selected and running; a fall that
    // starts a pause (pause line low) or ends one (hold_q high) is swallowed.
    assign shift_rise  = sck_rise & ~cs_n_s & ~hold_q;
    assign shift_fall  = sck_fall & ~cs_n_s & ~hold_q & hold_n_s;
    assign so_oe       = so_oe_req & ~cs_n_s & ~hold_q;
    assign xfer_abort  = cs_rise;
    assign hold_active = hold_q;

    a_r3_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !sck_s && !hold_n_s) |=> hold_active);
    a_r4_r6_defer_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && sck_s) |=> hold_active == $past(hold_active));
    a_r5_release_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !sck_s && hold_n_s) |=> !hold_active);
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (!shift_rise && !shift_fall));
    a_r9_so_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active || cs_n_s) |-> !so_oe);
    a_r10_desel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !hold_active);
endmodule

// File: rtl/spi_hold_sync.sv
// Module: top of the SPI pause synchroniser.
// Assumes the system clock is several times faster than SCK, so each SCK
// phase is seen for at least two system-clock cycles after synchronisation.
module spi_hold_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic hold_n_pin,
    input  logic si_pin,
    input  logic so_oe_req,
    output logic hold_active,
    output logic sel_active,
    output logic shift_rise,
    output logic shift_fall,
    output logic si_sync,
    output logic so_oe,
    output logic xfer_abort
);
    import spi_hold_pkg::*;

    localparam int EDGE_W = 2;  // bit 0: chip select, bit 1: serial clock

    logic [NUM_PINS-1:0] pins_raw, pins_s;
    logic [EDGE_W-1:0]   edge_in, edge_rise, edge_fall;

    assign pins_raw[PIN_CS]   = cs_n_pin;
    assign pins_raw[PIN_SCK]  = sck_pin;
    assign pins_raw[PIN_HOLD] = hold_n_pin;
    assign pins_raw[PIN_SI]   = si_pin;

    shp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    assign edge_in = {pins_s[PIN_SCK], pins_s[PIN_CS]};

    shp_edge #(.WIDTH(EDGE_W), .RST_VAL({PIN_IDLE[PIN_SCK], PIN_IDLE[PIN_CS]})) i_edge (
        .clk(clk), .rst_n(rst_n), .sig(edge_in), .rise(edge_rise), .fall(edge_fall)
    );

    shp_hold_ctl i_ctl (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(pins_s[PIN_CS]), .sck_s(pins_s[PIN_SCK]), .hold_n_s(pins_s[PIN_HOLD]),
        .sck_rise(edge_rise[1]), .sck_fall(edge_fall[1]), .cs_rise(edge_rise[0]),
        .so_oe_req(so_oe_req),
        .hold_active(hold_active), .shift_rise(shift_rise), .shift_fall(shift_fall),
        .so_oe(so_oe), .xfer_abort(xfer_abort)
    );

    assign sel_active = ~pins_s[PIN_CS];
    assign si_sync    = pins_s[PIN_SI];
endmodule

// File: tb/test_spi_hold_sync.sv
module test_spi_hold_sync;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_pin = 1'b1, sck_pin = 1'b0, hold_n_pin = 1'b1, si_pin = 1'b0, so_oe_req = 1'b0;
    logic hold_active, sel_active, shift_rise, shift_fall, si_sync, so_oe, xfer_abort;

    int checks = 0, fails = 0;
    int n_rise = 0, n_fall = 0, n_abort = 0;
    bit running = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_hold_sync i_spi_hold_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
        .hold_n_pin(hold_n_pin), .si_pin(si_pin), .so_oe_req(so_oe_req),
        .hold_active(hold_active), .sel_active(sel_active), .shift_rise(shift_rise),
        .shift_fall(shift_fall), .si_sync(si_sync), .so_oe(so_oe), .xfer_abort(xfer_abort)
    );

    // Strobe counters, sampled mid-cycle.
    always @(negedge clk) begin
        if (running) begin
            if (shift_rise) n_rise++;
            if (shift_fall) n_fall++;
            if (xfer_abort) n_abort++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sck_pin = 1'b1; step(4);
            sck_pin = 1'b0; step(4);
        end
    endtask

    task automatic t_reset;
        step(3);
        chk("R1 hold_active in reset", hold_active, 0);
        chk("R1 so_oe in reset", so_oe, 0);
        chk("R1 strobes in reset", shift_rise | shift_fall | xfer_abort, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 sel_active after reset", sel_active, 0);
        chk("R1 hold_active after reset", hold_active, 0);
        running = 1'b1;
    endtask

    task automatic t_run_shift;
        cs_n_pin = 1'b0; so_oe_req = 1'b1; si_pin = 1'b1;
        step(4);
        chk("R9 so_oe selected running", so_oe, 1);
        chk("R2 si_sync follows pin", si_sync, 1);
        n_rise = 0; n_fall = 0;
        sck_pulses(4);
        chk("R7 rise strobes", n_rise, 4);
        chk("R7 fall strobes", n_fall, 4);
    endtask

    task automatic t_enter_low;
        hold_n_pin = 1'b0;
        step(2);
        chk("R2 not yet after two edges", hold_active, 0);
        step(1);
        chk("R3 enter with SCK low", hold_active, 1);
        chk("R9 so_oe off in pause", so_oe, 0);
        n_rise = 0; n_fall = 0;
        sck_pulses(3);
        chk("R8 no rise strobes in pause", n_rise, 0);
        chk("R8 no fall strobes in pause", n_fall, 0);
        chk("R3 still paused", hold_active, 1);
    endtask

    task automatic t_release_low;
        hold_n_pin = 1'b1;
        step(2);
        chk("R2 release not yet", hold_active, 1);
        step(1);
        chk("R5 release with SCK low", hold_active, 0);
        chk("R9 so_oe back on", so_oe, 1);
    endtask

    task automatic t_enter_high;
        n_rise = 0; n_fall = 0;
        sck_pin = 1'b1; step(4);
        hold_n_pin = 1'b0;
        step(10);
        chk("R4 entry deferred while SCK high", hold_active, 0);
        sck_pin = 1'b0;
        step(2);
        chk("R4 not yet after fall", hold_active, 0);
        step(1);
        chk("R4 entry at SCK fall", hold_active, 1);
        step(2);
        chk("R7 rise before pause counted", n_rise, 1);
        chk("R8 fall starting pause swallowed", n_fall, 0);
    endtask

    task automatic t_release_high;
        n_rise = 0; n_fall = 0;
        sck_pin = 1'b1; step(4);
        hold_n_pin = 1'b1;
        step(10);
        chk("R6 release deferred while SCK high", hold_active, 1);
        sck_pin = 1'b0;
        step(3);
        chk("R6 release at SCK fall", hold_active, 0);
        step(2);
        chk("R8 rise during pause swallowed", n_rise, 0);
        chk("R8 fall ending pause swallowed", n_fall, 0);
    endtask

    task automatic t_deselect;
        hold_n_pin = 1'b0;
        step(4);
        chk("R3 paused before deselect", hold_active, 1);
        n_abort = 0;
        cs_n_pin = 1'b1;
        step(6);
        chk("R10 deselect clears pause", hold_active, 0);
        chk("R10 one abort pulse", n_abort, 1);
        chk("R9 so_oe off deselected", so_oe, 0);
        chk("R10 sel_active low", sel_active, 0);
        step(5);
        chk("R10 pause stays clear while deselected", hold_active, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_run_shift();
                t_enter_low();
                t_release_low();
                t_enter_high();
                t_release_high();
                t_deselect();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule